// File: doc/BRIEF.md
# I2C Slave Transmit Controller

This block is the read-direction half of an I2C target. It oversamples the bus lines with a fast system clock and recognises bus conditions (START, repeated START, STOP). After a START it shifts in a 7-bit address and the direction bit, and compares the address with a programmable own address. It can also compare it with the all-zero broadcast address. When the address matches and the master asks to read, the block acknowledges and then sets a select flag. It holds SCL low until host software has loaded a byte and written the status strobe.

Each byte that software supplies goes out MSB first. After the master's acknowledge slot the block sets a byte-end flag and stretches the clock again, whether or not the master acknowledged. On a not-acknowledge it stops driving SDA and waits for STOP or a repeated START. Every change the block makes on SDA is delayed by a programmable number of system clocks after it sees SCL fall. This sets the data hold time on the bus.

Top module: `i2cs_tx_top`

## Requirements
- R1: Reset releases both bus lines (scl_pull_low = 0, sda_pull_low = 0) and clears all three flags.
- R2: After a START, a 7-bit address equal to own_addr with the direction bit 1 (read) and ack_en = 1 gets an acknowledge: SDA is pulled low during the ninth SCL high phase. After the ninth SCL fall, irq_sel is 1 and SCL is pulled low.
- R3: An address matching neither the own address nor an enabled broadcast address gets no acknowledge and sets no flag. The block does not drive SDA or SCL again until the next START.
- R4: Address 0 is treated as a match only while gen_call_en = 1; with gen_call_en = 0 it is not acknowledged.
- R5: With ack_en = 0 a matching address is not acknowledged, sets no flag and does not stretch SCL.
- R6: A matching address with direction bit 0 (write) is acknowledged, but sets no flag, does not stretch SCL and leaves SDA released on the following byte.
- R7: A pulse on status_wr while SCL is stretched releases SCL. The byte last written through tx_wr/tx_data is sent MSB first, and SDA is stable while SCL is high.
- R8: After each transmitted byte's acknowledge slot, irq_tx_end is set and SCL is stretched. This happens both when the master acknowledged and when it did not. After an acknowledge, the next status_wr sends the byte then held in the data register.
- R9: After a master not-acknowledge and the following status_wr, the block leaves SDA released on all further SCL clocks until START or STOP.
- R10: A repeated START restarts address reception; a matching read address is then acknowledged and selected again.
- R11: A STOP seen after an address match sets irq_stop and releases both lines; a STOP while unaddressed sets no flag. Any status_wr pulse clears all three flags.
- R12: An SDA change takes effect sda_hold_clks system clocks after the edge at which the synchronised SCL fall is acted on. With two synchronizer stages this is at the third clock edge after the pin falls, plus sda_hold_clks. A value of 0 gives a change within that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL line level from the pad |
| sda_in | input | 1 | SDA line level from the pad |
| scl_pull_low | output | 1 | 1 drives SCL low (clock stretch) |
| sda_pull_low | output | 1 | 1 drives SDA low |
| own_addr | input | 7 | Programmed 7-bit own address |
| gen_call_en | input | 1 | Also accept address 0 |
| ack_en | input | 1 | Allow acknowledging an address match |
| sda_hold_clks | input | HOLD_W | SDA hold delay in system clocks |
| tx_wr | input | 1 | Write strobe for the transmit data register |
| tx_data | input | 8 | Transmit data to be written |
| status_wr | input | 1 | Status write strobe: clears flags, releases SCL |
| irq_sel | output | 1 | Slave-select flag |
| irq_tx_end | output | 1 | Byte-transmitted flag |
| irq_stop | output | 1 | STOP-after-selection flag |

## Verification
A wrong internal state usually shows on the bus within one SCL bit time. A mis-counted bit or a missed address compare appears as an acknowledge in the wrong slot, or as a byte read back with a shifted or corrupted value. A sequencer that fails to stop after a not-acknowledge keeps driving SDA on the following clocks, and the master reads something other than all ones. A stuck stretch or lost release shows up as SCL still held some ten system clocks after the status write. Hold-delay faults are caught at the exact clock edge where sda_pull_low should first change.

// File: rtl/i2cs_pkg.sv
// Shared types for the I2C slave transmit controller.
// Assumes: 7-bit addressing, 8-bit data bytes.
package i2cs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,      // waiting for START
        ST_ADDR,      // shifting in address and direction bit
        ST_ADDR_ACK,  // matched, ack goes out at next SCL fall
        ST_ACK_DRV,   // ack on bus until the ninth SCL fall
        ST_HOLD_SEL,  // SCL stretched after selection
        ST_TX_BIT,    // shifting a byte out
        ST_TX_ACK,    // master acknowledge slot
        ST_HOLD_TEND, // SCL stretched after a byte
        ST_WAIT_STOP  // passive until STOP or repeated START
    } i2cs_state_t;
endpackage

// File: rtl/i2cs_line_sync.sv
// Two-line synchroniser and bus-condition detector.
// Does: brings SCL (index 0) and SDA (index 1) into the clock domain through
// STAGES flops, keeps one extra delayed copy and derives SCL edges and
// START/STOP. Assumes: lines idle high; reset loads ones everywhere.
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_in,
    output logic       scl_lvl,
    output logic       sda_lvl,
    output logic       scl_rise,
    output logic       scl_fall,
    output logic       start_det,
    output logic       stop_det
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] prev;

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // Shift the pad level through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], line_in[g]};
        end
        assign lvl[g] = chain[STAGES-1];
        // Keep the previous synchronised level for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) prev[g] <= 1'b1;
            else        prev[g] <= lvl[g];
        end
    end

    assign scl_lvl   = lvl[0];
    assign sda_lvl   = lvl[1];
    assign scl_rise  = lvl[0] & ~prev[0];
    assign scl_fall  = ~lvl[0] & prev[0];
    assign start_det = lvl[0] & prev[0] & prev[1] & ~lvl[1];
    assign stop_det  = lvl[0] & prev[0] & ~prev[1] & lvl[1];
endmodule

// File: rtl/i2cs_hold_delay.sv
// SDA output hold-delay unit.
// Does: takes a requested SDA pull-low value on trig and applies it DLY
// clocks later; DLY = 0 applies it at the trig edge. clr releases SDA at once
// and cancels a pending change. Assumes: no new trig while busy.
module i2cs_hold_delay #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOLD_W-1:0] dly,
    input  logic              trig,
    input  logic              val,
    input  logic              clr,
    output logic              pull_low,
    output logic              busy
);
    localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

    logic [HOLD_W-1:0] cnt;
    logic              pend;

    // Count down the hold delay and land the pending value at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pull_low <= 1'b0;
            busy     <= 1'b0;
            cnt      <= '0;
            pend     <= 1'b0;
        end else if (trig) begin
            if (dly == '0) begin
                pull_low <= val;
            end else begin
                pend <= val;
                cnt  <= dly;
                busy <= 1'b1;
            end
        end else if (busy) begin
            cnt <= cnt - ONE;
            if (cnt == ONE) begin
                pull_low <= pend;
                busy     <= 1'b0;
            end
        end
    end

    // R12: a delayed request makes the unit busy on the next clock.
    p_delay_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !clr && dly != '0) |=> busy);

    // R12: when the count runs out the requested value appears on SDA.
    p_delay_land_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !trig && !clr && cnt == ONE) |=> (pull_low == $past(pend) && !busy));
endmodule

// File: rtl/i2cs_tx_top.sv
// I2C slave transmit controller, top level.
// Does: address phase, acknowledge, clock stretching, byte transmission and
// flag handling for the read direction. Assumes: clk oversamples SCL so that
// one SCL low phase spans more than 4 + sda_hold_clks system clocks.
module i2cs_tx_top
    import i2cs_pkg::*;
#(
    parameter int HOLD_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull_low,
    output logic              sda_pull_low,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gen_call_en,
    input  logic              ack_en,
    input  logic [HOLD_W-1:0] sda_hold_clks,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              status_wr,
    output logic              irq_sel,
    output logic              irq_tx_end,
    output logic              irq_stop
);
    localparam int          CNT_W     = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic trig, tval, dly_busy, bus_evt;

    i2cs_state_t       state, state_d;
    logic [ADDR_W-1:0] sreg, sreg_d;
    logic [CNT_W-1:0]  bitcnt, bitcnt_d;
    logic [DATA_W-2:0] shreg, shreg_d;
    logic [DATA_W-1:0] txreg;
    logic              rw_q, rw_d, mack_q, mack_d;
    logic              rel_pend, rel_d, next_tx, ntx_d;
    logic              set_sel, set_tend, set_stop;
    logic              addr_hit, selected;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   ({sda_in, scl_in}),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign bus_evt = start_det | stop_det;

    i2cs_hold_delay #(.HOLD_W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .dly      (sda_hold_clks),
        .trig     (trig),
        .val      (tval),
        .clr      (bus_evt),
        .pull_low (sda_pull_low),
        .busy     (dly_busy)
    );

    assign addr_hit = (sreg == own_addr) || (gen_call_en && sreg == '0);
    assign selected = (state != ST_IDLE) && (state != ST_ADDR);

    // Next-state and datapath decisions of the transfer sequencer.
    always_comb begin
        state_d  = state;
        sreg_d   = sreg;
        bitcnt_d = bitcnt;
        shreg_d  = shreg;
        rw_d     = rw_q;
        mack_d   = mack_q;
        rel_d    = rel_pend;
        ntx_d    = next_tx;
        trig     = 1'b0;
        tval     = 1'b0;
        set_sel  = 1'b0;
        set_tend = 1'b0;
        set_stop = 1'b0;
        if (start_det) begin
            state_d  = ST_ADDR;
            bitcnt_d = '0;
            rel_d    = 1'b0;
        end else if (stop_det) begin
            set_stop = selected;
            state_d  = ST_IDLE;
            rel_d    = 1'b0;
        end else begin
            unique case (state)
                ST_ADDR: if (scl_rise) begin
                    bitcnt_d = bitcnt + CNT_ONE;
                    if (bitcnt == LAST_ADDR) begin
                        rw_d    = sda_lvl;
                        state_d = (addr_hit && ack_en) ? ST_ADDR_ACK : ST_IDLE;
                    end else begin
                        sreg_d = {sreg[ADDR_W-2:0], sda_lvl};
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    trig    = 1'b1;
                    tval    = 1'b1;
                    state_d = ST_ACK_DRV;
                end
                ST_ACK_DRV: if (scl_fall) begin
                    trig = 1'b1;
                    if (rw_q) begin
                        set_sel = 1'b1;
                        state_d = ST_HOLD_SEL;
                    end else begin
                        state_d = ST_WAIT_STOP;
                    end
                end
                ST_HOLD_SEL, ST_HOLD_TEND: begin
                    if (rel_pend) begin
                        if (!dly_busy) begin
                            rel_d    = 1'b0;
                            bitcnt_d = '0;
                            state_d  = next_tx ? ST_TX_BIT : ST_WAIT_STOP;
                        end
                    end else if (status_wr) begin
                        rel_d = 1'b1;
                        ntx_d = (state == ST_HOLD_SEL) || mack_q;
                        if ((state == ST_HOLD_SEL) || mack_q) begin
                            shreg_d = txreg[DATA_W-2:0];
                            trig    = 1'b1;
                            tval    = ~txreg[DATA_W-1];
                        end
                    end
                end
                ST_TX_BIT: begin
                    if (scl_rise) begin
                        bitcnt_d = bitcnt + CNT_ONE;
                    end else if (scl_fall) begin
                        trig = 1'b1;
                        if (bitcnt == FULL_BYTE) begin
                            state_d = ST_TX_ACK;
                        end else begin
                            tval    = ~shreg[DATA_W-2];
                            shreg_d = {shreg[DATA_W-3:0], 1'b0};
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        mack_d = ~sda_lvl;
                    end else if (scl_fall) begin
                        set_tend = 1'b1;
                        state_d  = ST_HOLD_TEND;
                    end
                end
                default: ;
            endcase
        end
    end

    // Register the sequencer state and its datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sreg     <= '0;
            bitcnt   <= '0;
            shreg    <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            rel_pend <= 1'b0;
            next_tx  <= 1'b0;
        end else begin
            state    <= state_d;
            sreg     <= sreg_d;
            bitcnt   <= bitcnt_d;
            shreg    <= shreg_d;
            rw_q     <= rw_d;
            mack_q   <= mack_d;
            rel_pend <= rel_d;
            next_tx  <= ntx_d;
        end
    end

    // Host-written transmit data register.
    always_ff @(posedge clk) begin
        if (!rst_n)     txreg <= '0;
        else if (tx_wr) txreg <= tx_data;
    end

    // Interrupt flags: set by events, cleared by any status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_sel    <= 1'b0;
            irq_tx_end <= 1'b0;
            irq_stop   <= 1'b0;
        end else begin
            irq_sel    <= (irq_sel    & ~status_wr) | set_sel;
            irq_tx_end <= (irq_tx_end & ~status_wr) | set_tend;
            irq_stop   <= (irq_stop   & ~status_wr) | set_stop;
        end
    end

    assign scl_pull_low = (state == ST_HOLD_SEL) || (state == ST_HOLD_TEND);

    // R12: SDA only moves while SCL is low, or when a bus condition clears it.
    p_sda_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_low != $past(sda_pull_low)) |-> (!$past(scl_lvl) || $past(bus_evt)));

    // R2: a clock stretch begins only with a select or byte-end flag raised.
    p_stretch_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_low) |-> (irq_sel || irq_tx_end));

    // R11: STOP after selection raises the stop flag and frees the clock.
    p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && selected) |=> (irq_stop && !scl_pull_low && state == ST_IDLE));

    // R11: a status write with no concurrent event leaves all flags clear.
    p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_wr && !set_sel && !set_tend && !set_stop) |=> (!irq_sel && !irq_tx_end && !irq_stop));
endmodule

// File: tb/sim_i2cs_tx_top.sv
module sim_i2cs_tx_top;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 16;
    localparam int HOLD_W     = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic m_scl, m_sda;
    logic scl_pull_low, sda_pull_low;
    logic [6:0] own_addr;
    logic gen_call_en, ack_en;
    logic [HOLD_W-1:0] sda_hold_clks;
    logic tx_wr, status_wr;
    logic [7:0] tx_data;
    logic irq_sel, irq_tx_end, irq_stop;
    logic scl_bus, sda_bus;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_bus = m_scl & ~scl_pull_low;
    assign sda_bus = m_sda & ~sda_pull_low;

    i2cs_tx_top #(.HOLD_W(HOLD_W)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_bus),
        .sda_in        (sda_bus),
        .scl_pull_low  (scl_pull_low),
        .sda_pull_low  (sda_pull_low),
        .own_addr      (own_addr),
        .gen_call_en   (gen_call_en),
        .ack_en        (ack_en),
        .sda_hold_clks (sda_hold_clks),
        .tx_wr         (tx_wr),
        .tx_data       (tx_data),
        .status_wr     (status_wr),
        .irq_sel       (irq_sel),
        .irq_tx_end    (irq_tx_end),
        .irq_stop      (irq_stop)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_load(input logic [7:0] d);
        @(negedge clk); tx_wr = 1'b1; tx_data = d;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic host_status;
        @(negedge clk); status_wr = 1'b1;
        @(negedge clk); status_wr = 1'b0;
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wait_clk(HP);
        m_scl = 1'b1; wait_clk(HP);
        m_sda = 1'b0; wait_clk(HP);
        m_scl = 1'b0; wait_clk(HP);
    endtask

    task automatic bus_stop;
        wait_clk(2);
        m_sda = 1'b0; wait_clk(HP);
        m_scl = 1'b1; wait_clk(HP);
        m_sda = 1'b1; wait_clk(HP);
    endtask

    // One SCL clock; meas >= 0 checks the R12 SDA hold timing at the fall.
    task automatic clk_bit(input logic b, input int meas,
                           output logic seen, output logic unstable);
        logic first, last;
        wait_clk(2);
        m_sda = b; wait_clk(HP);
        m_scl = 1'b1;
        @(negedge clk);
        while (!scl_bus) @(negedge clk);
        wait_clk(1); first = sda_bus;
        wait_clk(HP/2); seen = sda_bus;
        wait_clk(HP/2); last = sda_bus;
        m_scl = 1'b0;
        unstable = (first != last) || (seen != first);
        if (meas >= 0) begin
            for (int k = 1; k <= 3 + meas; k++) begin
                @(negedge clk);
                if (k == 2 + meas)
                    chk(sda_pull_low == 1'b0, "R12", "SDA changed too early", sda_pull_low, 0);
                if (k == 3 + meas)
                    chk(sda_pull_low == 1'b1, "R12", "SDA not changed on time", sda_pull_low, 1);
            end
        end
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rw, input int meas,
                             output logic ack);
        logic s, u;
        for (int i = 6; i >= 0; i--) clk_bit(a[i], -1, s, u);
        clk_bit(rw, meas, s, u);
        clk_bit(1'b1, -1, ack, u);
        wait_clk(HP);
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] d, output logic unst);
        logic s, u;
        unst = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, -1, s, u);
            d[i] = s;
            unst = unst | u;
        end
        clk_bit(~mack, -1, s, u);
        wait_clk(HP);
    endtask

    task automatic t_reset;
        chk(scl_pull_low == 1'b0, "R1", "scl after reset", scl_pull_low, 0);
        chk(sda_pull_low == 1'b0, "R1", "sda after reset", sda_pull_low, 0);
        chk({irq_sel, irq_tx_end, irq_stop} == 3'b000, "R1", "flags after reset",
            {irq_sel, irq_tx_end, irq_stop}, 0);
    endtask

    task automatic t_read_flow(input int n);
        logic ack, u;
        logic [7:0] d;
        sda_hold_clks = HOLD_W'(n);
        bus_start;
        send_addr(7'h52, 1'b1, n, ack);
        chk(ack == 1'b0, "R2", "address ack", ack, 0);
        chk(irq_sel == 1'b1, "R2", "select flag", irq_sel, 1);
        chk(scl_pull_low == 1'b1, "R2", "stretch after select", scl_pull_low, 1);
        host_load(8'hA5);
        host_status;
        wait_clk(10);
        chk(scl_pull_low == 1'b0, "R7", "scl released", scl_pull_low, 0);
        chk(irq_sel == 1'b0, "R11", "select flag cleared", irq_sel, 0);
        read_byte(1'b1, d, u);
        chk(d == 8'hA5, "R7", "first byte", d, 8'hA5);
        chk(u == 1'b0, "R7", "sda stable while scl high", u, 0);
        chk(irq_tx_end == 1'b1, "R8", "byte-end flag after ack", irq_tx_end, 1);
        chk(scl_pull_low == 1'b1, "R8", "stretch after ack", scl_pull_low, 1);
        host_load(8'h3C);
        host_status;
        wait_clk(10);
        read_byte(1'b0, d, u);
        chk(d == 8'h3C, "R8", "second byte", d, 8'h3C);
        chk(irq_tx_end == 1'b1, "R8", "byte-end flag after nack", irq_tx_end, 1);
        chk(scl_pull_low == 1'b1, "R8", "stretch after nack", scl_pull_low, 1);
        host_status;
        wait_clk(10);
        chk(scl_pull_low == 1'b0, "R9", "scl released after nack", scl_pull_low, 0);
        read_byte(1'b0, d, u);
        chk(d == 8'hFF, "R9", "no drive after nack", d, 8'hFF);
        bus_stop;
        wait_clk(4);
        chk(irq_stop == 1'b1, "R11", "stop flag", irq_stop, 1);
        chk(scl_pull_low == 1'b0 && sda_pull_low == 1'b0, "R11", "lines free at stop",
            {scl_pull_low, sda_pull_low}, 0);
        host_status;
        wait_clk(2);
        chk(irq_stop == 1'b0, "R11", "stop flag cleared", irq_stop, 0);
    endtask

    task automatic t_mismatch;
        logic ack, u;
        logic [7:0] d;
        bus_start;
        send_addr(7'h11, 1'b1, -1, ack);
        chk(ack == 1'b1, "R3", "no ack on mismatch", ack, 1);
        chk({irq_sel, scl_pull_low} == 2'b00, "R3", "no select on mismatch",
            {irq_sel, scl_pull_low}, 0);
        read_byte(1'b1, d, u);
        chk(d == 8'hFF, "R3", "no drive after mismatch", d, 8'hFF);
        bus_stop;
        wait_clk(4);
        chk(irq_stop == 1'b0, "R11", "no stop flag when unaddressed", irq_stop, 0);
    endtask

    task automatic t_gcall;
        logic ack, u;
        logic [7:0] d;
        gen_call_en = 1'b0;
        bus_start;
        send_addr(7'h00, 1'b1, -1, ack);
        chk(ack == 1'b1, "R4", "broadcast refused when disabled", ack, 1);
        bus_stop;
        gen_call_en = 1'b1;
        bus_start;
        send_addr(7'h00, 1'b1, -1, ack);
        chk(ack == 1'b0, "R4", "broadcast acked when enabled", ack, 0);
        chk(irq_sel == 1'b1, "R4", "broadcast select flag", irq_sel, 1);
        host_load(8'h5A);
        host_status;
        wait_clk(10);
        read_byte(1'b0, d, u);
        chk(d == 8'h5A, "R4", "broadcast read byte", d, 8'h5A);
        host_status;
        bus_stop;
        host_status;
        gen_call_en = 1'b0;
    endtask

    task automatic t_ack_dis;
        logic ack;
        ack_en = 1'b0;
        bus_start;
        send_addr(7'h52, 1'b1, -1, ack);
        chk(ack == 1'b1, "R5", "no ack when disabled", ack, 1);
        chk({irq_sel, scl_pull_low} == 2'b00, "R5", "no select when disabled",
            {irq_sel, scl_pull_low}, 0);
        bus_stop;
        ack_en = 1'b1;
    endtask

    task automatic t_write_req;
        logic ack, u;
        logic [7:0] d;
        bus_start;
        send_addr(7'h52, 1'b0, -1, ack);
        chk(ack == 1'b0, "R6", "write address acked", ack, 0);
        chk({irq_sel, scl_pull_low} == 2'b00, "R6", "no select on write",
            {irq_sel, scl_pull_low}, 0);
        read_byte(1'b1, d, u);
        chk(d == 8'hFF, "R6", "no data driven on write", d, 8'hFF);
        bus_stop;
        host_status;
    endtask

    task automatic t_rstart;
        logic ack, u;
        logic [7:0] d;
        bus_start;
        send_addr(7'h52, 1'b1, -1, ack);
        host_load(8'hC3);
        host_status;
        wait_clk(10);
        read_byte(1'b0, d, u);
        host_status;
        wait_clk(10);
        bus_start;
        send_addr(7'h52, 1'b1, -1, ack);
        chk(ack == 1'b0, "R10", "ack after repeated start", ack, 0);
        chk(irq_sel == 1'b1, "R10", "select after repeated start", irq_sel, 1);
        host_load(8'h96);
        host_status;
        wait_clk(10);
        read_byte(1'b0, d, u);
        chk(d == 8'h96, "R10", "byte after repeated start", d, 8'h96);
        host_status;
        bus_stop;
        host_status;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
        own_addr = 7'h52; gen_call_en = 1'b0; ack_en = 1'b1;
        sda_hold_clks = '0; tx_wr = 1'b0; tx_data = '0; status_wr = 1'b0;
        wait_clk(5);
        t_reset;
        rst_n = 1'b1;
        wait_clk(5);
        t_reset;
        t_read_flow(0);
        t_read_flow(5);
        sda_hold_clks = '0;
        t_mismatch;
        t_gcall;
        t_ack_dis;
        t_write_req;
        t_rstart;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule